// File: doc/BRIEF.md
# Transition-Triggered Bit Synchronizer

This block recovers bit timing for a slow wireless receiver. It runs on a reference clock that oversamples each bit `P` times. The sliced data bit from the demodulator enters asynchronously and passes through two flops. When the synchronized data goes from 0 to 1, a phase counter restarts. The counter is loaded so that its value always gives the number of reference cycles since the edge reached the first flop. From then on, a one-cycle strobe fires once per bit period, at the phase equal to the active delay, and that strobe latches the recovered bit.

The delay comes from one of two sources. In external mode, software writes a cycle count into the delay input. In calibration mode, the block finds the delay itself. It waits out the rest of the bit in which the edge arrived. It then reads the amplitude sample bus at every phase of the next full bit and keeps the phase with the largest amplitude. Strobing with that phase starts in the bit after. A lock flag reports the first strobe made with a usable delay.

Top module: `bitsync_core`

## Requirements
- R1: After reset, `strobe`, `data_out` and `locked` are all 0.
- R2: Let edge cycle T be the clock edge at which `data_in` is first sampled high after being low. With `cal_mode`=0 and a delay D in 2..P-1, `strobe` is high for exactly one cycle, in the cycle that follows edge T+D.
- R3: Once strobing has started, `strobe` repeats every P cycles (cycles after T+D+k·P) for as long as no new rising edge arrives.
- R4: Every new 0-to-1 edge on `data_in` reloads the phase counter. Later strobes then follow the new edge exactly as in R2, whatever the phase was before.
- R5: `data_out` changes only at the clock edge that ends a strobe cycle. It takes the synchronized data, which is `data_in` as sampled one edge before the strobe cycle began. It holds its value between strobes.
- R6: `locked` rises in the cycle after the first strobe and stays high until reset or until `cal_start`.
- R7: With `cal_mode`=1, `amp_in` is sampled at every phase p = 0..P-1 of the bit that starts at edge T+P. Phase p covers the cycle after edge T+P+p. The first strobe then comes in the cycle after edge T+2P+B, where B is the phase of the largest amplitude, and strobes repeat every P cycles.
- R8: When several phases tie for the largest amplitude, B is the earliest of them.
- R9: No strobe occurs before the first rising edge, nor during the calibration bits before T+2P.
- R10: A `cal_start` pulse clears `locked` at the next edge and stops all strobes until a new rising edge starts the sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, P cycles per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 1 | Sliced demodulated data bit, asynchronous |
| amp_in | input | AMP_W | Amplitude sample of the demodulated waveform |
| cal_mode | input | 1 | 1: delay found by on-chip peak search; 0: delay from `dly_cfg` |
| cal_start | input | 1 | Restarts acquisition and clears lock |
| dly_cfg | input | DLY_W | Strobe delay in reference cycles for external mode |
| strobe | output | 1 | One-cycle sampling strobe |
| data_out | output | 1 | Recovered bit, updated on strobe |
| locked | output | 1 | High after the first valid strobe |

## Verification
All timing is counted from edge T. The bench raises `data_in` just after a falling edge, so the next rising edge is T. It then samples every output at the falling edge of each later cycle n. In external mode the strobe is due in cycle D, lock in cycle D+1, and the recovered bit in cycle D+1+k·P. In calibration mode the same results are due at 2P+B and 2P+B+1, with B worked out by a bench function from the amplitude table the bench itself drove. On a re-arm without reset, checks of the strobe and of the data are skipped for the two cycles, and up to D cycles respectively, in which the old phase legally still runs.

// File: rtl/bitsync_pkg.sv
package bitsync_pkg;

  // acquisition sequence of the synchronizer
  typedef enum logic [1:0] {
    ST_ARM,    // waiting for the first rising edge
    ST_SKIP,   // calibration: finishing the edge bit
    ST_SCAN,   // calibration: recording amplitude per phase
    ST_TRACK   // strobing once per bit
  } bs_state_t;

  // flops between the pin and the edge detector output
  localparam int SYNC_LAT = 2;

  // phase after cur in a counter of the given period
  function automatic logic [31:0] next_phase(input logic [31:0] cur, input int period);
    return (cur + 32'd1 >= 32'(period)) ? 32'd0 : cur + 32'd1;
  endfunction

  // a candidate replaces the held peak when it is the first sample or strictly larger
  function automatic logic amp_wins(input logic first, input logic [31:0] cand,
                                    input logic [31:0] held);
    return first || (cand > held);
  endfunction

endpackage

// File: rtl/bs_edge_sync.sv
module bs_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic sdata,
  output logic rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sdata = sync_q;
  assign rise  = sync_q & ~prev_q;
endmodule

// File: rtl/bs_phase_ctr.sv
module bs_phase_ctr import bitsync_pkg::*; #(
  parameter int P    = 16,
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  output logic [PH_W-1:0] ph,
  output logic            wrap
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ph <= '0;
    else if (load) ph <= PH_W'(SYNC_LAT);  // edge already two cycles old
    else           ph <= PH_W'(next_phase(32'(ph), P));
  end

  assign wrap = (32'(ph) == 32'(P - 1));
endmodule

// File: rtl/bs_peak_search.sv
module bs_peak_search import bitsync_pkg::*; #(
  parameter int PH_W  = 4,
  parameter int AMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic [PH_W-1:0]  ph,
  input  logic [AMP_W-1:0] amp,
  output logic [PH_W-1:0]  best_ph
);
  logic [AMP_W-1:0] best_amp;
  logic             take;

  assign take = en && amp_wins(ph == '0, 32'(amp), 32'(best_amp));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      best_amp <= '0;
      best_ph  <= '0;
    end else if (take) begin
      best_amp <= amp;
      best_ph  <= ph;
    end
  end
endmodule

// File: rtl/bitsync_core.sv
module bitsync_core import bitsync_pkg::*; #(
  parameter int P     = 16,
  parameter int DLY_W = 4,
  parameter int AMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_in,
  input  logic [AMP_W-1:0] amp_in,
  input  logic             cal_mode,
  input  logic             cal_start,
  input  logic [DLY_W-1:0] dly_cfg,
  output logic             strobe,
  output logic             data_out,
  output logic             locked
);
  localparam int PH_W = (P > 1) ? $clog2(P) : 1;

  bs_state_t       st;
  logic            sdata, rise, wrap, tracking, scan_en;
  logic [PH_W-1:0] ph, best_ph;
  logic [31:0]     eff32;

  bs_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .din(data_in), .sdata(sdata), .rise(rise)
  );

  bs_phase_ctr #(.P(P), .PH_W(PH_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(rise), .ph(ph), .wrap(wrap)
  );

  bs_peak_search #(.PH_W(PH_W), .AMP_W(AMP_W)) u_peak (
    .clk(clk), .rst_n(rst_n), .clear(cal_start), .en(scan_en),
    .ph(ph), .amp(amp_in), .best_ph(best_ph)
  );

  assign scan_en  = (st == ST_SCAN);
  assign tracking = (st == ST_TRACK);
  assign eff32    = cal_mode ? 32'(best_ph) : 32'(dly_cfg);
  assign strobe   = tracking && (32'(ph) == eff32);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_ARM;
      locked   <= 1'b0;
      data_out <= 1'b0;
    end else begin
      if (cal_start) begin
        st     <= ST_ARM;
        locked <= 1'b0;
      end else begin
        if (rise)                       st <= (tracking || !cal_mode) ? ST_TRACK : ST_SKIP;
        else if (st == ST_SKIP && wrap) st <= ST_SCAN;
        else if (st == ST_SCAN && wrap) st <= ST_TRACK;
        if (strobe) locked <= 1'b1;
      end
      if (strobe) data_out <= sdata;
    end
  end
endmodule

// File: rtl/bitsync_chk.sv
module bitsync_chk import bitsync_pkg::*; #(
  parameter int PH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cal_start,
  input logic            strobe,
  input logic            data_out,
  input logic            locked,
  input logic            rise,
  input logic [PH_W-1:0] ph
);
  assert_strobe_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  assert_rearm_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (ph == PH_W'(SYNC_LAT)));

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(data_out));

  assert_lock_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(strobe));

  assert_restart_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !locked);
endmodule

bind bitsync_core bitsync_chk #(.PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .strobe(strobe),
  .data_out(data_out), .locked(locked), .rise(rise), .ph(ph)
);

// File: tb/sim_bitsync_core.sv
module sim_bitsync_core;
  localparam int CLK_PERIOD = 10;
  localparam int P = 16;

  logic       clk = 1'b0, rst_n = 1'b0, data_in = 1'b0;
  logic       cal_mode = 1'b0, cal_start = 1'b0;
  logic [7:0] amp_in = '0;
  logic [3:0] dly_cfg = '0;
  logic       strobe, data_out, locked;
  logic [7:0] tab [P];
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bitsync_core #(.P(P), .DLY_W(4), .AMP_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .amp_in(amp_in),
    .cal_mode(cal_mode), .cal_start(cal_start), .dly_cfg(dly_cfg),
    .strobe(strobe), .data_out(data_out), .locked(locked)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // earliest phase holding the largest amplitude
  function automatic int peak_of();
    int b = 0;
    for (int p = 1; p < P; p++) if (tab[p] > tab[b]) b = p;
    return b;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; data_in = 1'b0; cal_start = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check("R1 strobe after reset", strobe, 0);
    check("R1 data_out after reset", data_out, 0);
    check("R1 locked after reset", locked, 0);
  endtask

  task automatic ext_run(input int d, input int nbits, input bit fresh);
    logic [7:0] bits;
    bits = 8'($urandom) | 8'h01;
    cal_mode = 1'b0; dly_cfg = 4'(d);
    @(negedge clk) data_in = 1'b1;
    for (int n = 0; n < nbits * P; n++) begin
      @(posedge clk); @(negedge clk);
      if (fresh || n >= 2)
        check(fresh ? (n < P ? "R2 first strobe" : "R3 periodic strobe") : "R4 re-arm strobe",
              strobe, int'(n >= 2 && n % P == d));
      check("R6 lock", locked, fresh ? int'(n >= d + 1) : 1);
      if (n > d) check("R5 recovered bit", data_out, int'(bits[(n - d - 1) / P]));
      else if (fresh) check("R5 data held before strobe", data_out, 0);
      data_in = ((n + 1) / P < nbits) ? bits[(n + 1) / P] : bits[nbits - 1];
    end
  endtask

  task automatic cal_run(input string tag, input int prev);
    int b;
    b = peak_of();
    cal_mode = 1'b1;
    @(negedge clk) data_in = 1'b1;
    for (int n = 0; n < 5 * P; n++) begin
      @(posedge clk); @(negedge clk);
      amp_in = tab[n % P];
      check(n < 2 * P ? "R9 no strobe while calibrating" : tag,
            strobe, int'(n >= 2 * P && (n - 2 * P) % P == b));
      check("R6 lock after calibration", locked, int'(n >= 2 * P + b + 1));
      check("R5 data after calibration", data_out, (n >= 2 * P + b + 1) ? 1 : prev);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int d, gap;
    void'($urandom(32'd2024));
    do_reset();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R9 idle strobe", strobe, 0);
      check("R1 idle lock", locked, 0);
    end

    // directed delay bounds, then random delays with a drifted re-arm
    do_reset(); ext_run(2, 4, 1'b1);
    do_reset(); ext_run(15, 4, 1'b1);
    for (int r = 0; r < 4; r++) begin
      d = $urandom_range(15, 2);
      do_reset(); ext_run(d, 4, 1'b1);
      gap = $urandom_range(20, 4);
      data_in = 1'b0;
      repeat (gap) @(negedge clk);
      ext_run(d, 3, 1'b0);
    end

    // calibration: peak at first and last phase, ties, random tables
    for (int p = 0; p < P; p++) tab[p] = 8'(10 + p);
    tab[0] = 8'd200;
    do_reset(); cal_run("R7 peak at phase 0", 0);
    for (int p = 0; p < P; p++) tab[p] = 8'(p * 3);
    do_reset(); cal_run("R7 peak at last phase", 0);
    for (int p = 0; p < P; p++) tab[p] = 8'(20 + p % 4);
    tab[5] = 8'd90; tab[11] = 8'd90;
    do_reset(); cal_run("R8 tie earliest", 0);
    for (int p = 0; p < P; p++) tab[p] = 8'd77;
    do_reset(); cal_run("R8 all equal", 0);
    for (int r = 0; r < 3; r++) begin
      for (int p = 0; p < P; p++) tab[p] = 8'($urandom_range(255, 0));
      do_reset(); cal_run("R7 random table", 0);
    end

    // restart calibration without reset
    @(negedge clk) cal_start = 1'b1;
    @(negedge clk) cal_start = 1'b0;
    check("R10 lock cleared", locked, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check("R10 no strobe after restart", strobe, 0);
    end
    data_in = 1'b0;
    repeat (4) @(negedge clk);
    for (int p = 0; p < P; p++) tab[p] = 8'($urandom_range(255, 0));
    cal_run("R10 recalibrated strobe", 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule